// File: doc/BRIEF.md
# Flash Status Busy-Bit Poller

This block runs a status-read command against a serial flash device. Once a start pulse is accepted, it drives chip select low, sends the status opcode through a byte-wide shifter shared with the command sequencer, and then sends zero bytes to collect status bytes from the flash. In hardware polling mode it keeps requesting status bytes while a selected bit of the latest byte is 1. That bit, normally the write-in-progress flag, sits at a position chosen by a 3-bit field. In software mode it collects exactly one status byte and stops.

Each status byte that comes back is stored in a readable status register. When the command ends, chip select is released and a done pulse is raised for one cycle. An abort input ends the command at the next byte boundary. The shifter is reached through a request/complete handshake: `xfer_req_o` starts one byte, and `xfer_done_i` later reports that the byte has finished, with the byte received from the flash on `xfer_rx_i`.

Top module: `flash_busy_poller`

## Requirements
- R1: After reset, `cs_n_o` is 1, `xfer_req_o` and `done_o` are 0, and `status_o` is 0x00.
- R2: A start pulse is ignored unless `stat_flag_i` is 1 and `wr_flag_i` is 0. An ignored start leaves `cs_n_o` high, issues no byte and raises no done pulse.
- R3: The cycle after a start is accepted, `cs_n_o` goes low and a single one-cycle byte request carries the opcode latched at start. The opcode is sent exactly once per command.
- R4: Every byte request after the opcode carries the value 0x00.
- R5: In hardware mode (`sw_mode_i` = 0), another status byte is requested while bit `busy_pos` of the byte just received is 1. Polling ends at the first byte in which that bit is 0.
- R6: The busy position is sampled from `busy_pos_i` at start and may be any of bits 0 to 7.
- R7: In software mode (`sw_mode_i` = 1), exactly one status byte is read, whatever its value.
- R8: `status_o` takes each received status byte one cycle after its `xfer_done_i`, and holds its value at all other times. The opcode byte's response is never stored.
- R9: `cs_n_o` stays low for the whole command, including the gaps between bytes. It rises in the same cycle as the done pulse.
- R10: `done_o` is a single-cycle pulse, raised one cycle after the completion of the last byte.
- R11: An abort raised while a command is active ends it when the byte in flight completes. If that byte is a status byte it is stored. Chip select is released and done is pulsed.
- R12: A start pulse that arrives while a command is active has no effect on that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle command start |
| stat_flag_i | input | 1 | Command is flagged as a status read |
| wr_flag_i | input | 1 | Command is flagged as a write |
| sw_mode_i | input | 1 | 1: single status byte, 0: poll busy bit |
| opcode_i | input | 8 | Status-read opcode |
| busy_pos_i | input | 3 | Bit position of the busy flag in the status byte |
| abort_i | input | 1 | Stop at the next byte boundary |
| xfer_req_o | output | 1 | One-cycle request to shift one byte |
| xfer_tx_o | output | 8 | Byte to send with the request |
| xfer_done_i | input | 1 | Shifter finished the requested byte |
| xfer_rx_i | input | 8 | Byte received from the flash, valid with done |
| cs_n_o | output | 1 | Active-low flash chip select |
| done_o | output | 1 | One-cycle command-finished pulse |
| status_o | output | 8 | Last status byte received |

## Verification
Chip select falls and the opcode request appears one cycle after the clock edge that accepts a start. Each further request appears one cycle after the `xfer_done_i` edge it follows. The status byte, the rise of chip select and the done pulse all land one cycle after the completing `xfer_done_i`. The bench drives inputs and samples outputs on the falling edge, so everything is read half a cycle after the edge that produces it. A cycle-level model advanced on each rising edge predicts all five outputs for that same half-cycle point. Directed checks at the done pulse then count the bytes requested and read the stored status against the value that the busy-bit rule predicts.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC_ISSUE,
      ST_OPC_WAIT,
      ST_RD_ISSUE,
      ST_RD_WAIT
   } seq_state_e;
endpackage

// File: rtl/fbp_cmd_latch.sv
module fbp_cmd_latch #(
   parameter int DATA_W = 8,
   parameter int POS_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stat_flag_i,
   input  logic              wr_flag_i,
   input  logic              sw_mode_i,
   input  logic [DATA_W-1:0] opcode_i,
   input  logic [POS_W-1:0]  busy_pos_i,
   input  logic              idle_i,
   output logic              accept_o,
   output logic [DATA_W-1:0] opcode_q,
   output logic              sw_q,
   output logic [POS_W-1:0]  pos_q
);
   // only a status read that is not a write, and only while idle
   assign accept_o = start_i & stat_flag_i & ~wr_flag_i & idle_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opcode_q <= '0;
         sw_q     <= 1'b0;
         pos_q    <= '0;
      end else if (accept_o) begin
         opcode_q <= opcode_i;
         sw_q     <= sw_mode_i;
         pos_q    <= busy_pos_i;
      end
   end

   // R12: configuration is frozen while a command runs
   p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> $stable(opcode_q) && $stable(pos_q) && $stable(sw_q));
endmodule

// File: rtl/fbp_busy_test.sv
module fbp_busy_test #(
   parameter int DATA_W = 8,
   parameter int POS_W  = 3
) (
   input  logic [DATA_W-1:0] rx_i,
   input  logic [POS_W-1:0]  pos_i,
   output logic              busy_o
);
   logic [DATA_W-1:0] hit;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      assign hit[g] = (pos_i == POS_W'(g)) & rx_i[g];
   end

   assign busy_o = |hit;
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
   import fbp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic [DATA_W-1:0] opcode_i,
   input  logic              sw_i,
   input  logic              busy_i,
   input  logic              abort_i,
   input  logic              xfer_done_i,
   input  logic [DATA_W-1:0] xfer_rx_i,
   output logic              xfer_req_o,
   output logic [DATA_W-1:0] xfer_tx_o,
   output logic              cs_n_o,
   output logic              done_o,
   output logic [DATA_W-1:0] status_o,
   output logic              idle_o
);
   seq_state_e state, state_nx;
   logic       abort_pend;
   logic       finish;
   logic       capture;

   assign idle_o     = (state == ST_IDLE);
   assign cs_n_o     = idle_o;
   assign xfer_req_o = (state == ST_OPC_ISSUE) || (state == ST_RD_ISSUE);
   assign xfer_tx_o  = (state == ST_OPC_ISSUE) ? opcode_i : '0;
   assign capture    = (state == ST_RD_WAIT) && xfer_done_i;

   always_comb begin
      state_nx = state;
      finish   = 1'b0;
      unique case (state)
         ST_IDLE:      if (accept_i) state_nx = ST_OPC_ISSUE;
         ST_OPC_ISSUE: state_nx = ST_OPC_WAIT;
         ST_OPC_WAIT:
            if (xfer_done_i) begin
               if (abort_pend || abort_i) finish = 1'b1;
               else                       state_nx = ST_RD_ISSUE;
            end
         ST_RD_ISSUE:  state_nx = ST_RD_WAIT;
         ST_RD_WAIT:
            if (xfer_done_i) begin
               if (sw_i || !busy_i || abort_pend || abort_i) finish = 1'b1;
               else                                          state_nx = ST_RD_ISSUE;
            end
         default:      state_nx = ST_IDLE;
      endcase
      if (finish) state_nx = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         done_o     <= 1'b0;
         abort_pend <= 1'b0;
         status_o   <= '0;
      end else begin
         state  <= state_nx;
         done_o <= finish;
         if (capture) status_o <= xfer_rx_i;
         if (finish)                 abort_pend <= 1'b0;
         else if (!idle_o && abort_i) abort_pend <= 1'b1;
      end
   end

   // R3: every byte request lasts exactly one cycle
   p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o |=> !xfer_req_o);
   // R9: chip select is only released together with the done pulse
   p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> done_o);
   // R10: done never lasts two cycles
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8: stored status changes only after a completed byte
   p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_done_i |=> $stable(status_o));
   // R11: abort with a completing byte always ends the command
   p_abort_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && xfer_done_i && !idle_o && !xfer_req_o) |=> cs_n_o && done_o);
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stat_flag_i,
   input  logic              wr_flag_i,
   input  logic              sw_mode_i,
   input  logic [DATA_W-1:0] opcode_i,
   input  logic [$clog2(DATA_W)-1:0] busy_pos_i,
   input  logic              abort_i,
   output logic              xfer_req_o,
   output logic [DATA_W-1:0] xfer_tx_o,
   input  logic              xfer_done_i,
   input  logic [DATA_W-1:0] xfer_rx_i,
   output logic              cs_n_o,
   output logic              done_o,
   output logic [DATA_W-1:0] status_o
);
   localparam int POS_W = $clog2(DATA_W);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("flash_busy_poller: DATA_W must be a power of two of at least 2");
   end

   logic              accept;
   logic              idle;
   logic [DATA_W-1:0] opc_q;
   logic              sw_q;
   logic [POS_W-1:0]  pos_q;
   logic              busy;

   fbp_cmd_latch #(.DATA_W(DATA_W), .POS_W(POS_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .stat_flag_i(stat_flag_i),
      .wr_flag_i  (wr_flag_i),
      .sw_mode_i  (sw_mode_i),
      .opcode_i   (opcode_i),
      .busy_pos_i (busy_pos_i),
      .idle_i     (idle),
      .accept_o   (accept),
      .opcode_q   (opc_q),
      .sw_q       (sw_q),
      .pos_q      (pos_q)
   );

   fbp_busy_test #(.DATA_W(DATA_W), .POS_W(POS_W)) u_busy (
      .rx_i  (xfer_rx_i),
      .pos_i (pos_q),
      .busy_o(busy)
   );

   fbp_seq #(.DATA_W(DATA_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .opcode_i   (opc_q),
      .sw_i       (sw_q),
      .busy_i     (busy),
      .abort_i    (abort_i),
      .xfer_done_i(xfer_done_i),
      .xfer_rx_i  (xfer_rx_i),
      .xfer_req_o (xfer_req_o),
      .xfer_tx_o  (xfer_tx_o),
      .cs_n_o     (cs_n_o),
      .done_o     (done_o),
      .status_o   (status_o),
      .idle_o     (idle)
   );

   // R2: a start that is flagged as a write never opens chip select
   p_reject_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_o && start_i && wr_flag_i) |=> cs_n_o);
endmodule

// File: tb/tb_flash_busy_poller.sv
module tb_flash_busy_poller;
   localparam int LAT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 0, stat_flag_i = 0, wr_flag_i = 0, sw_mode_i = 0, abort_i = 0;
   logic [7:0] opcode_i = 0;
   logic [2:0] busy_pos_i = 0;
   logic       xfer_done_i = 0;
   logic [7:0] xfer_rx_i = 0;
   logic       xfer_req_o, cs_n_o, done_o;
   logic [7:0] xfer_tx_o, status_o;

   always #2 clk = ~clk;

   flash_busy_poller dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stat_flag_i(stat_flag_i),
      .wr_flag_i(wr_flag_i), .sw_mode_i(sw_mode_i), .opcode_i(opcode_i),
      .busy_pos_i(busy_pos_i), .abort_i(abort_i), .xfer_req_o(xfer_req_o),
      .xfer_tx_o(xfer_tx_o), .xfer_done_i(xfer_done_i), .xfer_rx_i(xfer_rx_i),
      .cs_n_o(cs_n_o), .done_o(done_o), .status_o(status_o)
   );

   int compared = 0, mismatched = 0;
   int req_cnt = 0, done_cnt = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- flash + shifter model ----------------
   logic [7:0] rsp_q[$];
   logic [7:0] fill = 8'h00;
   int         sh_cnt = 0;

   // ---------------- reference model ----------------
   int         m_ph = 0;
   bit         m_ab = 0, m_sw = 0, m_done = 0;
   int         m_pos = 0;
   logic [7:0] m_opc = 0, m_stat = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_ab = 0; m_sw = 0; m_done = 0; m_pos = 0; m_opc = 0; m_stat = 0;
      end else begin
         bit fin;
         fin    = 0;
         m_done = 0;
         case (m_ph)
            0: if (start_i && stat_flag_i && !wr_flag_i) begin
                  m_ph = 1; m_opc = opcode_i; m_sw = sw_mode_i; m_pos = busy_pos_i;
               end
            1: m_ph = 2;
            2: if (xfer_done_i) begin
                  if (m_ab || abort_i) fin = 1; else m_ph = 3;
               end
            3: m_ph = 4;
            4: if (xfer_done_i) begin
                  m_stat = xfer_rx_i;
                  if (m_sw || !xfer_rx_i[m_pos] || m_ab || abort_i) fin = 1; else m_ph = 3;
               end
            default: m_ph = 0;
         endcase
         if (fin) begin
            m_ph = 0; m_done = 1; m_ab = 0;
         end else if (m_ph != 0 && abort_i) begin
            m_ab = 1;
         end
      end
   end

   // compare, count and drive the shifter, half a cycle after each edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(cs_n_o == (m_ph == 0), "R9 cs_n", cs_n_o, (m_ph == 0));
         chk(xfer_req_o == (m_ph == 1 || m_ph == 3), "R3 req", xfer_req_o, (m_ph == 1 || m_ph == 3));
         chk(xfer_tx_o == ((m_ph == 1) ? m_opc : 8'h00), "R4 tx", xfer_tx_o, (m_ph == 1) ? m_opc : 8'h00);
         chk(status_o == m_stat, "R8 status", status_o, m_stat);
         chk(done_o == m_done, "R10 done", done_o, m_done);
         if (xfer_req_o) req_cnt++;
         if (done_o) done_cnt++;
      end
      xfer_done_i = (sh_cnt == 1);
      if (sh_cnt == 1) xfer_rx_i = (rsp_q.size() > 0) ? rsp_q.pop_front() : fill;
      if (sh_cnt > 0) sh_cnt--;
      if (rst_n && xfer_req_o) sh_cnt = LAT;
   end

   // run a command and check byte count and stored status at done
   task automatic run_cmd(input logic [7:0] opc, input bit sw, input int pos,
                          input int exp_polls, input logic [7:0] exp_stat, input string tag);
      int base, waited;
      @(negedge clk);
      opcode_i = opc; sw_mode_i = sw; busy_pos_i = 3'(pos);
      stat_flag_i = 1; wr_flag_i = 0; start_i = 1;
      base = req_cnt;
      @(negedge clk);
      start_i = 0;
      waited = 0;
      while (!done_o && waited < 2000) begin
         @(negedge clk); waited++;
      end
      chk(done_o == 1'b1, {tag, " done seen"}, done_o, 1);
      chk(cs_n_o == 1'b1, {tag, " cs released"}, cs_n_o, 1);
      chk(req_cnt - base - 1 == exp_polls, {tag, " status bytes"}, req_cnt - base - 1, exp_polls);
      chk(status_o == exp_stat, {tag, " stored status"}, status_o, exp_stat);
      @(negedge clk);
      chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(cs_n_o == 1, "R1 cs_n reset", cs_n_o, 1);
      chk(xfer_req_o == 0, "R1 req reset", xfer_req_o, 0);
      chk(done_o == 0, "R1 done reset", done_o, 0);
      chk(status_o == 8'h00, "R1 status reset", status_o, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2: write-flagged and non-status starts are ignored
      begin
         int base_r, base_d;
         bit cs_ok;
         base_r = req_cnt; base_d = done_cnt; cs_ok = 1;
         opcode_i = 8'h05; stat_flag_i = 1; wr_flag_i = 1; start_i = 1;
         @(negedge clk); start_i = 0;
         repeat (3) begin @(negedge clk); if (!cs_n_o) cs_ok = 0; end
         stat_flag_i = 0; wr_flag_i = 0; start_i = 1;
         @(negedge clk); start_i = 0;
         repeat (8) begin @(negedge clk); if (!cs_n_o) cs_ok = 0; end
         chk(cs_ok, "R2 cs stays high", cs_ok, 1);
         chk(req_cnt == base_r, "R2 no byte issued", req_cnt - base_r, 0);
         chk(done_cnt == base_d, "R2 no done", done_cnt - base_d, 0);
      end

      // R7: software mode, one byte even if busy
      rsp_q = {8'h5A, 8'hFF};
      run_cmd(8'h05, 1, 0, 1, 8'hFF, "R7 sw single");

      // R5: hardware polling on bit 0
      rsp_q = {8'h5A, 8'h01, 8'h03, 8'h01, 8'h00};
      run_cmd(8'h05, 0, 0, 4, 8'h00, "R5 poll bit0");

      // R6: busy at bit 5, other bits set do not matter
      rsp_q = {8'h5A, 8'h20, 8'hDF};
      run_cmd(8'h35, 0, 5, 2, 8'hDF, "R6 poll bit5");

      // R6: busy at bit 7
      rsp_q = {8'h5A, 8'h80, 8'hFF, 8'h7F};
      run_cmd(8'h15, 0, 7, 3, 8'h7F, "R6 poll bit7");

      // R5: first byte already idle
      rsp_q = {8'h5A, 8'hFB};
      run_cmd(8'h05, 0, 2, 1, 8'hFB, "R5 ready at once");

      // R11: abort during polling
      begin
         int base, waited;
         fill = 8'hFF; rsp_q = {8'h5A};
         base = req_cnt;
         opcode_i = 8'h05; sw_mode_i = 0; busy_pos_i = 0; stat_flag_i = 1; wr_flag_i = 0;
         start_i = 1; @(negedge clk); start_i = 0;
         repeat (14) @(negedge clk);
         chk(cs_n_o == 0, "R9 cs held while polling", cs_n_o, 0);
         abort_i = 1; @(negedge clk); abort_i = 0;
         waited = 0;
         while (!done_o && waited < 50) begin @(negedge clk); waited++; end
         chk(done_o == 1, "R11 abort ends polling", done_o, 1);
         chk(cs_n_o == 1, "R11 cs released", cs_n_o, 1);
         chk(status_o == 8'hFF, "R11 last byte stored", status_o, 8'hFF);
         chk(req_cnt - base < 8, "R11 bounded bytes", req_cnt - base, 7);
         fill = 8'h00;
         repeat (3) @(negedge clk);
      end

      // R11: abort during opcode byte, no status stored
      begin
         int base, waited;
         rsp_q = {8'h5A};
         base = req_cnt;
         opcode_i = 8'h05; sw_mode_i = 0; start_i = 1; @(negedge clk);
         start_i = 0; abort_i = 1; @(negedge clk); abort_i = 0;
         waited = 0;
         while (!done_o && waited < 50) begin @(negedge clk); waited++; end
         chk(done_o == 1, "R11 abort in opcode", done_o, 1);
         chk(req_cnt - base == 1, "R11 opcode only", req_cnt - base, 1);
         chk(status_o == 8'hFF, "R11 status kept", status_o, 8'hFF);
         repeat (3) @(negedge clk);
      end

      // R12: second start during a command is ignored
      begin
         int base, base_d, waited;
         rsp_q = {8'h5A, 8'h02, 8'h02, 8'h02, 8'h00};
         base = req_cnt; base_d = done_cnt;
         opcode_i = 8'h05; sw_mode_i = 0; busy_pos_i = 1; start_i = 1;
         @(negedge clk); start_i = 0;
         repeat (3) @(negedge clk);
         opcode_i = 8'h33; sw_mode_i = 1; busy_pos_i = 4; start_i = 1;
         @(negedge clk); start_i = 0;
         waited = 0;
         while (!done_o && waited < 200) begin @(negedge clk); waited++; end
         chk(req_cnt - base == 5, "R12 bytes unchanged", req_cnt - base, 5);
         chk(status_o == 8'h00, "R12 status", status_o, 0);
         repeat (4) @(negedge clk);
         chk(done_cnt - base_d == 1, "R12 single done", done_cnt - base_d, 1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule